// File: doc/BRIEF.md
# Service Channel Message Dispatcher

This block sits between a tile's network interface and the units that listen on the shared service virtual channel. Each incoming message carries a message-type field. For synchronization traffic, a sub-type field in the payload says which unit takes it. The dispatcher raises the valid line of exactly one consumer: the boot/host handler, the synchronization accounting unit, the core-side release port or the IO handler.

The dispatcher returns a single consumed acknowledgement to the network interface. That acknowledgement is taken from whichever consumer was chosen. Messages with a type or sub-type code that no consumer owns are acknowledged straight away and dropped, so one bad message cannot stall the channel. The block is purely combinational and holds no state, so a consumer's acknowledgement reaches the network interface in the same cycle.

Message-type codes: 0 = host, 1 = synchronization, 2 = IO, 3 = unused. The synchronization sub-type occupies the top SUB_W bits of the payload: 0 = account, 1 = release, other codes unused.

Top module: `svc_dispatch`

## Requirements
- R1: A valid message of type 0 (host) raises only boot_valid, and in_consumed equals boot_consumed.
- R2: A valid message of type 1 whose payload sub-type (top SUB_W bits) is 0 (account) raises only acct_valid, and in_consumed equals acct_consumed.
- R3: A valid message of type 1 whose sub-type is 1 (release) raises only rel_valid, and in_consumed equals rel_consumed.
- R4: A valid message of type 2 (IO) raises only io_valid, and in_consumed equals io_consumed.
- R5: While in_valid is 0, all consumer valid outputs and in_consumed are 0, whatever the consumers' consumed inputs are.
- R6: At most one consumer valid output is 1 at any time. The consumed input of a consumer that is not selected has no effect on in_consumed.
- R7: A valid message of type 3, or of type 1 with a sub-type other than 0 or 1, raises no consumer valid and drives in_consumed to 1.
- R8: Every consumer payload output equals in_data bit for bit.
- R9: The sub-type bits do not affect routing for messages of type 0 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Message present on the service channel |
| in_type | input | TYPE_W | Message-type code |
| in_data | input | DATA_W | Message payload; top SUB_W bits hold the sync sub-type |
| in_consumed | output | 1 | Acknowledgement to the network interface |
| boot_valid | output | 1 | Message offered to the boot/host handler |
| boot_data | output | DATA_W | Payload to the boot/host handler |
| boot_consumed | input | 1 | Boot/host handler took the message |
| acct_valid | output | 1 | Message offered to the sync accounting unit |
| acct_data | output | DATA_W | Payload to the sync accounting unit |
| acct_consumed | input | 1 | Accounting unit took the message |
| rel_valid | output | 1 | Message offered to the core release port |
| rel_data | output | DATA_W | Payload to the core release port |
| rel_consumed | input | 1 | Core took the release message |
| io_valid | output | 1 | Message offered to the IO handler |
| io_data | output | DATA_W | Payload to the IO handler |
| io_consumed | input | 1 | IO handler took the message |

## Verification
The bench builds the block with its defaults: a 32-bit payload, a 2-bit type field and a 2-bit sub-type field. With 2-bit fields, every unused code can be driven: type 3, and sub-types 2 and 3. This exercises the drop path for both decode levels. Each routed case is run twice, once with only the selected consumer acknowledging and once with only the other consumers acknowledging. A leaked acknowledgement therefore shows up at in_consumed.

// File: rtl/svc_disp_pkg.sv
// Shared codes for the service channel dispatcher.
// Assumes the type field is at least 2 bits and the sub-type field at least 1 bit wide.
package svc_disp_pkg;
    localparam int unsigned TYPE_W_DEF = 2;
    localparam int unsigned SUB_W_DEF  = 2;
    localparam int unsigned DATA_W_DEF = 32;

    // Message-type codes carried on the channel
    localparam int unsigned KIND_HOST = 0;
    localparam int unsigned KIND_SYNC = 1;
    localparam int unsigned KIND_IO   = 2;

    // Synchronization sub-type codes
    localparam int unsigned SYNC_ACCOUNT = 0;
    localparam int unsigned SYNC_RELEASE = 1;

    // Consumer slots, in fan-out order
    typedef enum int unsigned {
        SLOT_BOOT = 0,
        SLOT_ACCT = 1,
        SLOT_REL  = 2,
        SLOT_IO   = 3
    } slot_e;
    localparam int unsigned NUM_SLOTS = 4;
endpackage

// File: rtl/svc_route_decode.sv
// Two-level route decode: message type first, then the sync sub-type.
// Produces a one-hot-or-zero slot select and a drop flag for unknown codes.
// Assumes in_valid qualifies the other inputs.
module svc_route_decode
    import svc_disp_pkg::*;
#(
    parameter int unsigned TYPE_W = TYPE_W_DEF,
    parameter int unsigned SUB_W  = SUB_W_DEF
) (
    input  logic                 in_valid,
    input  logic [TYPE_W-1:0]    in_type,
    input  logic [SUB_W-1:0]     in_sub,
    output logic [NUM_SLOTS-1:0] sel,
    output logic                 drop
);
    // Choose the consumer slot from type and sub-type
    always_comb begin
        sel  = '0;
        drop = 1'b0;
        if (in_valid) begin
            if (in_type == TYPE_W'(KIND_HOST)) begin
                sel[SLOT_BOOT] = 1'b1;
            end else if (in_type == TYPE_W'(KIND_SYNC)) begin
                if (in_sub == SUB_W'(SYNC_ACCOUNT)) begin
                    sel[SLOT_ACCT] = 1'b1;
                end else if (in_sub == SUB_W'(SYNC_RELEASE)) begin
                    sel[SLOT_REL] = 1'b1;
                end else begin
                    drop = 1'b1;
                end
            end else if (in_type == TYPE_W'(KIND_IO)) begin
                sel[SLOT_IO] = 1'b1;
            end else begin
                drop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/svc_ack_select.sv
// Picks the acknowledgement of the selected consumer, or forces it for a drop.
// Assumes sel is one-hot or zero and drop excludes any select.
module svc_ack_select #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] sel,
    input  logic         drop,
    input  logic [N-1:0] cons,
    output logic         ack
);
    // Merge the masked consumer acknowledgements with the drop path
    always_comb begin
        ack = drop | (|(sel & cons));
    end
endmodule

// File: rtl/svc_fanout.sv
// Drives the valid and payload of every consumer slot.
// Payload is broadcast unchanged; only the selected slot sees valid.
module svc_fanout #(
    parameter int unsigned N      = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic [N-1:0]            sel,
    input  logic [DATA_W-1:0]       data,
    output logic [N-1:0]            out_valid,
    output logic [N-1:0][DATA_W-1:0] out_data
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        // Per-slot valid and payload
        always_comb begin
            out_valid[g] = sel[g];
            out_data[g]  = data;
        end
    end
endmodule

// File: rtl/svc_dispatch.sv
// Service channel dispatcher: steers one network-interface message stream to
// the boot, sync-account, release or IO consumer and returns the chosen
// consumer's acknowledgement. Purely combinational; the sync sub-type is read
// from the top SUB_W bits of the payload.
module svc_dispatch
    import svc_disp_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned TYPE_W = TYPE_W_DEF,
    parameter int unsigned SUB_W  = SUB_W_DEF
) (
    input  logic              in_valid,
    input  logic [TYPE_W-1:0] in_type,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_consumed,
    output logic              boot_valid,
    output logic [DATA_W-1:0] boot_data,
    input  logic              boot_consumed,
    output logic              acct_valid,
    output logic [DATA_W-1:0] acct_data,
    input  logic              acct_consumed,
    output logic              rel_valid,
    output logic [DATA_W-1:0] rel_data,
    input  logic              rel_consumed,
    output logic              io_valid,
    output logic [DATA_W-1:0] io_data,
    input  logic              io_consumed
);
    localparam int unsigned SUB_LSB = DATA_W - SUB_W;

    logic [NUM_SLOTS-1:0]             sel;
    logic                             drop;
    logic [NUM_SLOTS-1:0]             cons_vec;
    logic [NUM_SLOTS-1:0]             val_vec;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] data_vec;
    logic [SUB_W-1:0]                 sub_fld;

    // Extract the sync sub-type and gather the consumer acknowledgements
    always_comb begin
        sub_fld             = in_data[SUB_LSB +: SUB_W];
        cons_vec            = '0;
        cons_vec[SLOT_BOOT] = boot_consumed;
        cons_vec[SLOT_ACCT] = acct_consumed;
        cons_vec[SLOT_REL]  = rel_consumed;
        cons_vec[SLOT_IO]   = io_consumed;
    end

    svc_route_decode #(.TYPE_W(TYPE_W), .SUB_W(SUB_W)) u_decode (
        .in_valid (in_valid),
        .in_type  (in_type),
        .in_sub   (sub_fld),
        .sel      (sel),
        .drop     (drop)
    );

    svc_ack_select #(.N(NUM_SLOTS)) u_ack (
        .sel  (sel),
        .drop (drop),
        .cons (cons_vec),
        .ack  (in_consumed)
    );

    svc_fanout #(.N(NUM_SLOTS), .DATA_W(DATA_W)) u_fan (
        .sel       (sel),
        .data      (in_data),
        .out_valid (val_vec),
        .out_data  (data_vec)
    );

    // Map slot vectors onto the named consumer ports
    always_comb begin
        boot_valid = val_vec[SLOT_BOOT];
        boot_data  = data_vec[SLOT_BOOT];
        acct_valid = val_vec[SLOT_ACCT];
        acct_data  = data_vec[SLOT_ACCT];
        rel_valid  = val_vec[SLOT_REL];
        rel_data   = data_vec[SLOT_REL];
        io_valid   = val_vec[SLOT_IO];
        io_data    = data_vec[SLOT_IO];
    end

    // Port-level checks on the combined behaviour
    always_comb begin
        // R6
        single_sel_chk: assert ($onehot0({boot_valid, acct_valid, rel_valid, io_valid}));
        // R5
        idle_quiet_chk: assert (in_valid || !(boot_valid || acct_valid || rel_valid || io_valid || in_consumed));
        // R7
        drop_ack_chk: assert (!in_valid || boot_valid || acct_valid || rel_valid || io_valid || in_consumed);
        // R1
        boot_ack_chk: assert (!boot_valid || (in_consumed == boot_consumed));
        // R2
        acct_ack_chk: assert (!acct_valid || (in_consumed == acct_consumed));
        // R3
        rel_ack_chk: assert (!rel_valid || (in_consumed == rel_consumed));
        // R4
        io_ack_chk: assert (!io_valid || (in_consumed == io_consumed));
        // R8
        pass_data_chk: assert (boot_data == in_data && acct_data == in_data && rel_data == in_data && io_data == in_data);
    end
endmodule

// File: tb/svc_dispatch_tb.sv
module svc_dispatch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 32;
    localparam int TYPE_W = 2;
    localparam int SUB_W  = 2;
    localparam int NVEC   = 15;

    // Vector layout: valid | exp_consumed | type[2] | 00 | sub[2] | cons{io,rel,acct,boot} | exp_valid{io,rel,acct,boot}
    localparam logic [15:0] VEC [NVEC] = '{
        16'b1_0_00_00_00_0000_0001, // R1 host, no ack
        16'b1_1_00_00_00_0001_0001, // R1 host, boot ack
        16'b1_0_00_00_00_1110_0001, // R6 host, others ack
        16'b1_1_01_00_00_0010_0010, // R2 account, acct ack
        16'b1_0_01_00_00_1101_0010, // R6 account, others ack
        16'b1_1_01_00_01_0100_0100, // R3 release, core ack
        16'b1_0_01_00_01_1011_0100, // R6 release, others ack
        16'b1_1_10_00_00_1000_1000, // R4 IO, io ack
        16'b1_0_10_00_00_0111_1000, // R6 IO, others ack
        16'b1_1_11_00_00_0000_0000, // R7 type 3 dropped
        16'b1_1_01_00_10_1111_0000, // R7 sub-type 2 dropped
        16'b1_1_01_00_11_0000_0000, // R7 sub-type 3 dropped
        16'b0_0_00_00_00_1111_0000, // R5 idle, all ack
        16'b0_0_11_00_00_1111_0000, // R5 idle, bad type
        16'b1_1_00_00_11_0001_0001  // R9 host with odd sub-type
    };

    logic clk = 1'b0;
    logic in_valid = 1'b0;
    logic [TYPE_W-1:0] in_type = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic in_consumed;
    logic boot_valid, acct_valid, rel_valid, io_valid;
    logic [DATA_W-1:0] boot_data, acct_data, rel_data, io_data;
    logic boot_consumed = 1'b0, acct_consumed = 1'b0, rel_consumed = 1'b0, io_consumed = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    svc_dispatch #(.DATA_W(DATA_W), .TYPE_W(TYPE_W), .SUB_W(SUB_W)) dut_i (
        .in_valid(in_valid), .in_type(in_type), .in_data(in_data), .in_consumed(in_consumed),
        .boot_valid(boot_valid), .boot_data(boot_data), .boot_consumed(boot_consumed),
        .acct_valid(acct_valid), .acct_data(acct_data), .acct_consumed(acct_consumed),
        .rel_valid(rel_valid), .rel_data(rel_data), .rel_consumed(rel_consumed),
        .io_valid(io_valid), .io_data(io_data), .io_consumed(io_consumed)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic v, input logic [1:0] t, input logic [1:0] s,
                         input logic [3:0] c, input logic [29:0] pat);
        @(negedge clk);
        in_valid      = v;
        in_type       = t;
        in_data       = {s, pat};
        boot_consumed = c[0];
        acct_consumed = c[1];
        rel_consumed  = c[2];
        io_consumed   = c[3];
        #1;
    endtask

    initial begin
        // Idle state before any message
        #1;
        check("R5 idle valids", 64'({io_valid, rel_valid, acct_valid, boot_valid}), 64'h0);
        check("R5 idle consumed", 64'(in_consumed), 64'h0);

        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] v = VEC[i];
            logic [29:0] pat = 30'h0ABC_1230 + 30'(i * 30'h0111_0101);
            apply(v[15], v[13:12], v[9:8], v[7:4], pat);
            check("R1-4/R6/R7/R9 valids", 64'({io_valid, rel_valid, acct_valid, boot_valid}), 64'(v[3:0]));
            check("R1-4/R5/R7 consumed", 64'(in_consumed), 64'(v[14]));
            check("R8 payload", 64'({boot_data ^ in_data, acct_data ^ in_data, rel_data ^ in_data, io_data ^ in_data}), 64'h0);
            check("R8 boot payload value", 64'(boot_data), 64'({v[9:8], pat}));
        end

        // R6: selected consumer acknowledgement toggles while others stay high
        apply(1'b1, 2'd2, 2'd0, 4'b0111, 30'h1);
        check("R6 io low ack", 64'(in_consumed), 64'h0);
        apply(1'b1, 2'd2, 2'd0, 4'b1111, 30'h1);
        check("R6 io high ack", 64'(in_consumed), 64'h1);
        // R9: IO with sub-type 1 still goes to IO
        apply(1'b1, 2'd2, 2'd1, 4'b0000, 30'h2);
        check("R9 io odd sub", 64'({io_valid, rel_valid, acct_valid, boot_valid}), 64'b1000);
        // R5: valid dropped back low clears everything
        apply(1'b0, 2'd1, 2'd1, 4'b1111, 30'h3);
        check("R5 release idle", 64'({io_valid, rel_valid, acct_valid, boot_valid, in_consumed}), 64'h0);
        // R8: all-ones payload passes unchanged
        apply(1'b1, 2'd0, 2'd3, 4'b0000, 30'h3FFF_FFFF);
        check("R8 all ones", 64'(boot_data), 64'hFFFF_FFFF);
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 2000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule